// File: doc/BRIEF.md
# Packet Data Port

This block gives a host word-wide access to a packet buffer RAM through two registers. A pointer register carries a byte offset plus three mode bits: transfer direction, which packet the access targets (the packet number register or the packet at the head of the receive queue), and automatic advance. A data register is the window onto the word the pointer names. Each accepted data access moves the pointer forward by one 16-bit word when automatic advance is on. Writes are posted through a small buffer, and a flag in the pointer register shows that buffer is still draining. Reads are prefetched, so the word at the pointer is already waiting in the data register.

Beside the access path sits a combinational frame layout unit. It computes the fields a driver places around a payload in packet memory. On transmit these are the byte-count word, the trailing control word that carries an odd last byte, and a flag for frames too large to allocate. On receive it recovers the payload length and the odd-length flag from the stored count and control words. The buffer RAM is a behavioural model inside the block.

Top module: `pktdata_port`

## Requirements
- R1: The pointer reads back as bit 15 = read direction, bit 14 = automatic advance, bit 13 = receive-area select, bit 12 = write-pending flag, bits [OFF_W-1:0] = word-aligned byte offset, and all other bits zero. On a pointer load, offset bit 0 and bits 12..OFF_W of the written value are ignored.
- R2: With automatic advance set, each accepted data access adds 2 to the offset, wrapping modulo 2^OFF_W. With it clear, the offset does not change.
- R3: An accepted data write is posted into a WB_DEPTH-entry buffer. The buffer drains one entry per cycle into RAM, and the write-pending flag is high exactly while the buffer holds an entry.
- R4: A pointer load is dropped when the write buffer is not empty, or when a data write is accepted in the same cycle; that data write then uses the old pointer.
- R5: A pointer load with the read bit set puts the addressed word on dat_rdata after the next clock edge. Each accepted data read puts the word at the advanced pointer on dat_rdata after its own clock edge, so back-to-back reads stream successive words. A RAM read never coincides with a pending write.
- R6: With receive-area select set, accesses target packet rx_head_pkt. With it clear, they target the packet number register.
- R7: A data write while the pointer is in read mode, and a data read while it is in write mode, change neither the RAM, the pointer nor dat_rdata.
- R8: tx_count_word equals max(tx_len, 60) + 6.
- R9: tx_ctl_word has bit 13 set and the last byte in bits [7:0] when the padded length is odd, and is zero when it is even.
- R10: tx_too_big is high when (padded length rounded down to even) + 6 is at least 2048.
- R11: rx_len is (rx_count_raw & 0x7FF) − 6, or 0 when that masked count is below 6. rx_odd equals bit 13 of rx_ctl_raw.
- R12: After reset the pointer reads 0, the write-pending flag is low and dat_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_we | input | 1 | Load the packet number register |
| pkt_wdata | input | PKT_W | Packet number to load |
| rx_head_pkt | input | PKT_W | Packet number at the head of the receive queue |
| ptr_we | input | 1 | Load the pointer register |
| ptr_wdata | input | 16 | Pointer value to load |
| ptr_rdata | output | 16 | Pointer readback with write-pending flag |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 16 | Data word to write |
| dat_re | input | 1 | Data register read strobe (consumes the current word) |
| dat_rdata | output | 16 | Prefetched data word |
| wr_pending | output | 1 | Posted writes not yet in RAM |
| tx_len | input | 11 | Transmit payload length in bytes |
| tx_last_byte | input | 8 | Last payload byte for odd lengths |
| tx_count_word | output | 16 | Byte-count word to store |
| tx_ctl_word | output | 16 | Trailing control word to store |
| tx_too_big | output | 1 | Frame exceeds the allocation limit |
| rx_count_raw | input | 16 | Count word read from a received packet |
| rx_ctl_raw | input | 16 | Control word read from a received packet |
| rx_len | output | 11 | Recovered receive payload length |
| rx_odd | output | 1 | Received frame has an odd last byte |

## Verification
Two collisions are provoked on purpose. Back-to-back data writes make a buffer push and a RAM drain share every cycle. Those words are later streamed back with back-to-back prefetched reads and compared one by one. In the second collision, a pointer load lands in the same cycle as a draining buffer, and a pointer load lands together with a data write. The pointer readback after that edge must show the load dropped and the write advancing the old offset, and the written word must appear at the old address.

// File: rtl/pktdata_pkg.sv
package pktdata_pkg;

    localparam int WORD_W       = 16;
    localparam int LEN_W        = 11;
    localparam int PAD_MIN      = 60;
    localparam int LAYOUT_OVH   = 6;
    localparam int ODD_FLAG_BIT = 13;
    localparam int ALLOC_LIMIT  = 2048;

    // pointer register bit positions
    localparam int PF_READ = 15;
    localparam int PF_AUTO = 14;
    localparam int PF_RXSEL = 13;
    localparam int PF_PEND = 12;

    typedef struct packed {
        logic rd;
        logic auto_inc;
        logic rx_sel;
    } ptr_mode_t;

    function automatic logic [LEN_W-1:0] padded_len(input logic [LEN_W-1:0] len);
        return (len < LEN_W'(PAD_MIN)) ? LEN_W'(PAD_MIN) : len;
    endfunction

    function automatic logic [WORD_W-1:0] make_ctl(input logic [LEN_W-1:0] plen,
                                                   input logic [7:0] last);
        logic [WORD_W-1:0] w;
        w = '0;
        if (plen[0]) begin
            w[ODD_FLAG_BIT] = 1'b1;
            w[7:0] = last;
        end
        return w;
    endfunction

    function automatic logic [LEN_W-1:0] rx_payload(input logic [LEN_W-1:0] cnt);
        return (cnt < LEN_W'(LAYOUT_OVH)) ? '0 : cnt - LEN_W'(LAYOUT_OVH);
    endfunction

endpackage

// File: rtl/pktdata_wbuf.sv
module pktdata_wbuf #(
    parameter int W     = 26,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     slots [DEPTH];
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(DEPTH-1)) ? '0 : i + IDX_W'(1);
    endfunction

    logic do_push, do_pop;
    assign do_pop  = pop && (cnt_q != '0);
    assign do_push = push && ((cnt_q != CNT_W'(DEPTH)) || do_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            rd_idx <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_idx <= bump(wr_idx);
            if (do_pop)  rd_idx <= bump(rd_idx);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_idx] <= din;
    end

    assign dout  = slots[rd_idx];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign count = cnt_q;
endmodule

// File: rtl/pktdata_ram.sv
module pktdata_ram #(
    parameter int AW = 11,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/pktdata_frame_fmt.sv
module pktdata_frame_fmt
    import pktdata_pkg::*;
(
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [7:0]        tx_last_byte,
    output logic [WORD_W-1:0] tx_count_word,
    output logic [WORD_W-1:0] tx_ctl_word,
    output logic              tx_too_big,
    input  logic [WORD_W-1:0] rx_count_raw,
    input  logic [WORD_W-1:0] rx_ctl_raw,
    output logic [LEN_W-1:0]  rx_len,
    output logic              rx_odd
);
    logic [LEN_W-1:0] plen;
    logic [LEN_W:0]   alloc_bytes;

    always_comb begin
        plen          = padded_len(tx_len);
        tx_count_word = WORD_W'(plen) + WORD_W'(LAYOUT_OVH);
        tx_ctl_word   = make_ctl(plen, tx_last_byte);
        alloc_bytes   = {1'b0, plen[LEN_W-1:1], 1'b0} + (LEN_W+1)'(LAYOUT_OVH);
        tx_too_big    = (alloc_bytes >= (LEN_W+1)'(ALLOC_LIMIT));
        rx_len        = rx_payload(rx_count_raw[LEN_W-1:0]);
        rx_odd        = rx_ctl_raw[ODD_FLAG_BIT];
    end

    logic unused_fmt_bits;
    assign unused_fmt_bits = ^{rx_count_raw[WORD_W-1:LEN_W],
                               rx_ctl_raw[WORD_W-1:ODD_FLAG_BIT+1],
                               rx_ctl_raw[ODD_FLAG_BIT-1:0]};
endmodule

// File: rtl/pktdata_port.sv
module pktdata_port
    import pktdata_pkg::*;
#(
    parameter int PKT_W    = 2,
    parameter int OFF_W    = 10,
    parameter int WB_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_we,
    input  logic [PKT_W-1:0]  pkt_wdata,
    input  logic [PKT_W-1:0]  rx_head_pkt,
    input  logic              ptr_we,
    input  logic [15:0]       ptr_wdata,
    output logic [15:0]       ptr_rdata,
    input  logic              dat_we,
    input  logic [15:0]       dat_wdata,
    input  logic              dat_re,
    output logic [15:0]       dat_rdata,
    output logic              wr_pending,
    input  logic [10:0]       tx_len,
    input  logic [7:0]        tx_last_byte,
    output logic [15:0]       tx_count_word,
    output logic [15:0]       tx_ctl_word,
    output logic              tx_too_big,
    input  logic [15:0]       rx_count_raw,
    input  logic [15:0]       rx_ctl_raw,
    output logic [10:0]       rx_len,
    output logic              rx_odd
);
    localparam int ADDR_W = PKT_W + OFF_W - 1;
    localparam int ENT_W  = ADDR_W + WORD_W;
    localparam int CNT_W  = $clog2(WB_DEPTH+1);

    ptr_mode_t         mode_q;
    logic [OFF_W-1:0]  off_q;
    logic [PKT_W-1:0]  pkt_q;

    logic              wb_empty, wb_full, wb_pop;
    logic [ENT_W-1:0]  wb_head;
    logic [CNT_W-1:0]  wb_count;

    logic [PKT_W-1:0]  cur_pkt, load_pkt;
    logic [OFF_W-1:0]  off_step, off_adv, load_off;
    logic              wr_acc, rd_acc, ld_acc;
    logic              ram_rd_en;
    logic [ADDR_W-1:0] ram_raddr;
    logic [ENT_W-1:0]  push_ent;

    // ---- access decode ----
    always_comb begin
        cur_pkt  = mode_q.rx_sel ? rx_head_pkt : pkt_q;
        load_pkt = ptr_wdata[PF_RXSEL] ? rx_head_pkt : pkt_q;
        load_off = {ptr_wdata[OFF_W-1:1], 1'b0};
        off_step = mode_q.auto_inc ? OFF_W'(2) : '0;
        off_adv  = off_q + off_step;
        wb_pop   = !wb_empty;
        wr_acc   = dat_we && !mode_q.rd && (!wb_full || wb_pop);
        rd_acc   = dat_re && mode_q.rd;
        ld_acc   = ptr_we && wb_empty && !wr_acc;
        push_ent = {cur_pkt, off_q[OFF_W-1:1], dat_wdata};
    end

    // ---- prefetch address: new pointer on load, advanced pointer on read ----
    always_comb begin
        ram_rd_en = (ld_acc && ptr_wdata[PF_READ]) || rd_acc;
        if (ld_acc) ram_raddr = {load_pkt, load_off[OFF_W-1:1]};
        else        ram_raddr = {cur_pkt, off_adv[OFF_W-1:1]};
    end

    // ---- pointer and packet registers ----
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            off_q  <= '0;
            pkt_q  <= '0;
        end else begin
            if (pkt_we) pkt_q <= pkt_wdata;
            if (ld_acc) begin
                mode_q.rd       <= ptr_wdata[PF_READ];
                mode_q.auto_inc <= ptr_wdata[PF_AUTO];
                mode_q.rx_sel   <= ptr_wdata[PF_RXSEL];
                off_q           <= load_off;
            end else if (wr_acc || rd_acc) begin
                off_q <= off_adv;
            end
        end
    end

    // ---- posted write buffer ----
    pktdata_wbuf #(.W(ENT_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_acc),
        .din   (push_ent),
        .pop   (wb_pop),
        .dout  (wb_head),
        .empty (wb_empty),
        .full  (wb_full),
        .count (wb_count)
    );

    // ---- packet buffer RAM ----
    pktdata_ram #(.AW(ADDR_W), .DW(WORD_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .we    (wb_pop),
        .waddr (wb_head[ENT_W-1:WORD_W]),
        .wdata (wb_head[WORD_W-1:0]),
        .re    (ram_rd_en),
        .raddr (ram_raddr),
        .rdata (dat_rdata)
    );

    // ---- frame layout helper ----
    pktdata_frame_fmt u_fmt (
        .tx_len        (tx_len),
        .tx_last_byte  (tx_last_byte),
        .tx_count_word (tx_count_word),
        .tx_ctl_word   (tx_ctl_word),
        .tx_too_big    (tx_too_big),
        .rx_count_raw  (rx_count_raw),
        .rx_ctl_raw    (rx_ctl_raw),
        .rx_len        (rx_len),
        .rx_odd        (rx_odd)
    );

    // ---- readback ----
    always_comb begin
        ptr_rdata           = '0;
        ptr_rdata[OFF_W-1:0] = off_q;
        ptr_rdata[PF_PEND]  = !wb_empty;
        ptr_rdata[PF_RXSEL] = mode_q.rx_sel;
        ptr_rdata[PF_AUTO]  = mode_q.auto_inc;
        ptr_rdata[PF_READ]  = mode_q.rd;
    end

    assign wr_pending = !wb_empty;

    logic unused_ptr_bits;
    assign unused_ptr_bits = ^{ptr_wdata[PF_PEND:OFF_W], ptr_wdata[0]};
endmodule

// File: rtl/pktdata_port_chk.sv
module pktdata_port_chk #(
    parameter int OFF_W    = 10,
    parameter int WB_DEPTH = 2,
    parameter int CNT_W    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ptr_we,
    input logic             dat_we,
    input logic             dat_re,
    input logic [15:0]      ptr_rdata,
    input logic             wr_pending,
    input logic [CNT_W-1:0] wb_count,
    input logic             ram_rd_en
);
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        wb_count <= CNT_W'(WB_DEPTH));

    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_we && !ptr_rdata[15]) |=> wr_pending);

    // R3
    pend_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_pending && !dat_we) |=> !wr_pending);

    // R4
    load_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_pending && ptr_we && !dat_we) |=>
            $stable({ptr_rdata[15:13], ptr_rdata[OFF_W-1:0]}));

    // R2
    auto_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_we && !ptr_rdata[15] && ptr_rdata[14]) |=>
            (ptr_rdata[OFF_W-1:0] == OFF_W'($past(ptr_rdata[OFF_W-1:0]) + OFF_W'(2))));

    // R7
    rd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_re && !ptr_rdata[15] && !dat_we && !ptr_we) |=> $stable(ptr_rdata[OFF_W-1:0]));

    // R5
    prefetch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        ram_rd_en |-> !wr_pending);
endmodule

bind pktdata_port pktdata_port_chk #(
    .OFF_W(OFF_W), .WB_DEPTH(WB_DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ptr_we     (ptr_we),
    .dat_we     (dat_we),
    .dat_re     (dat_re),
    .ptr_rdata  (ptr_rdata),
    .wr_pending (wr_pending),
    .wb_count   (wb_count),
    .ram_rd_en  (ram_rd_en)
);

// File: tb/pktdata_port_test.sv
`timescale 1ns/1ps
module pktdata_port_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_we = 1'b0;
    logic [1:0]  pkt_wdata = '0;
    logic [1:0]  rx_head_pkt = '0;
    logic        ptr_we = 1'b0;
    logic [15:0] ptr_wdata = '0;
    logic [15:0] ptr_rdata;
    logic        dat_we = 1'b0;
    logic [15:0] dat_wdata = '0;
    logic        dat_re = 1'b0;
    logic [15:0] dat_rdata;
    logic        wr_pending;
    logic [10:0] tx_len = '0;
    logic [7:0]  tx_last_byte = '0;
    logic [15:0] tx_count_word, tx_ctl_word;
    logic        tx_too_big;
    logic [15:0] rx_count_raw = '0, rx_ctl_raw = '0;
    logic [10:0] rx_len;
    logic        rx_odd;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    pktdata_port uut (
        .clk(clk), .rst(rst), .pkt_we(pkt_we), .pkt_wdata(pkt_wdata),
        .rx_head_pkt(rx_head_pkt), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .ptr_rdata(ptr_rdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
        .dat_re(dat_re), .dat_rdata(dat_rdata), .wr_pending(wr_pending),
        .tx_len(tx_len), .tx_last_byte(tx_last_byte), .tx_count_word(tx_count_word),
        .tx_ctl_word(tx_ctl_word), .tx_too_big(tx_too_big),
        .rx_count_raw(rx_count_raw), .rx_ctl_raw(rx_ctl_raw),
        .rx_len(rx_len), .rx_odd(rx_odd)
    );

    typedef struct packed {
        logic [10:0] len;
        logic [7:0]  lb;
        logic [15:0] ecnt;
        logic [15:0] ectl;
        logic        ebig;
        logic [15:0] rraw;
        logic [15:0] rctl;
        logic [10:0] erlen;
        logic        erodd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{11'd0,    8'hAA, 16'h0042, 16'h0000, 1'b0, 16'h0042, 16'h0000, 11'd60,   1'b0},
        '{11'd59,   8'h11, 16'h0042, 16'h0000, 1'b0, 16'hF843, 16'h205C, 11'd61,   1'b1},
        '{11'd60,   8'h22, 16'h0042, 16'h0000, 1'b0, 16'h0005, 16'h0000, 11'd0,    1'b0},
        '{11'd61,   8'h5C, 16'h0043, 16'h205C, 1'b0, 16'h07FF, 16'h2000, 11'd2041, 1'b1},
        '{11'd1514, 8'h33, 16'h05F0, 16'h0000, 1'b0, 16'h05F0, 16'h0000, 11'd1514, 1'b0},
        '{11'd1515, 8'h7F, 16'h05F1, 16'h207F, 1'b0, 16'h8006, 16'h0000, 11'd0,    1'b0},
        '{11'd2041, 8'h44, 16'h07FF, 16'h2044, 1'b0, 16'h0803, 16'h2000, 11'd0,    1'b1},
        '{11'd2042, 8'h55, 16'h0800, 16'h0000, 1'b1, 16'hFFFF, 16'h1FFF, 11'd2041, 1'b0},
        '{11'd2047, 8'h66, 16'h0805, 16'h2066, 1'b1, 16'h0006, 16'hDFFF, 11'd0,    1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_ptr(input logic [15:0] v);
        ptr_we = 1'b1; ptr_wdata = v; step(); ptr_we = 1'b0;
    endtask

    task automatic wr_word(input logic [15:0] d);
        dat_we = 1'b1; dat_wdata = d; step(); dat_we = 1'b0;
    endtask

    task automatic rd_word;
        dat_re = 1'b1; step(); dat_re = 1'b0;
    endtask

    task automatic set_pkt(input logic [1:0] p);
        pkt_we = 1'b1; pkt_wdata = p; step(); pkt_we = 1'b0;
    endtask

    localparam logic [15:0] WD [5] = '{16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555};

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 ptr after reset", ptr_rdata, 16'h0000);
        chk("R12 pending after reset", {15'd0, wr_pending}, 16'h0000);
        chk("R12 data after reset", dat_rdata, 16'h0000);

        // frame layout table: R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            tx_len = VECS[i].len; tx_last_byte = VECS[i].lb;
            rx_count_raw = VECS[i].rraw; rx_ctl_raw = VECS[i].rctl;
            #1;
            chk("R8 count word", tx_count_word, VECS[i].ecnt);
            chk("R9 control word", tx_ctl_word, VECS[i].ectl);
            chk("R10 too big", {15'd0, tx_too_big}, {15'd0, VECS[i].ebig});
            chk("R11 rx length", {5'd0, rx_len}, {5'd0, VECS[i].erlen});
            chk("R11 rx odd", {15'd0, rx_odd}, {15'd0, VECS[i].erodd});
        end

        // posted writes, back-to-back
        set_pkt(2'd1);
        load_ptr(16'h4000);
        chk("R1 pointer load", ptr_rdata, 16'h4000);
        wr_word(WD[0]);
        chk("R3 pending after write", {15'd0, wr_pending}, 16'h0001);
        chk("R2 advance on write", ptr_rdata, 16'h5002);
        for (int i = 1; i < 5; i++) wr_word(WD[i]);
        chk("R3 pending at last write", ptr_rdata, 16'h500A);
        load_ptr(16'h0000);
        chk("R4 load dropped while pending", ptr_rdata, 16'h400A);
        chk("R3 drained", {15'd0, wr_pending}, 16'h0000);

        // streamed reads
        load_ptr(16'hC000);
        chk("R5 prefetch on load", dat_rdata, WD[0]);
        for (int i = 1; i < 5; i++) begin
            rd_word();
            chk("R5 streamed read", dat_rdata, WD[i]);
        end
        chk("R2 advance on read", ptr_rdata, 16'hC008);

        // read without advance
        load_ptr(16'h8004);
        chk("R5 prefetch mid packet", dat_rdata, WD[2]);
        rd_word();
        chk("R2 no advance data", dat_rdata, WD[2]);
        chk("R2 no advance ptr", ptr_rdata, 16'h8004);

        // direction filtering
        wr_word(16'hDEAD);
        chk("R7 write ignored pending", {15'd0, wr_pending}, 16'h0000);
        chk("R7 write ignored ptr", ptr_rdata, 16'h8004);
        load_ptr(16'h8004);
        chk("R7 write ignored ram", dat_rdata, WD[2]);
        load_ptr(16'h4006);
        rd_word();
        chk("R7 read ignored ptr", ptr_rdata, 16'h4006);
        chk("R7 read ignored data", dat_rdata, WD[2]);

        // receive area select
        rx_head_pkt = 2'd2;
        load_ptr(16'h6000);
        wr_word(16'hA0A0);
        wr_word(16'hA1A1);
        set_pkt(2'd2);
        load_ptr(16'hC000);
        chk("R6 rx area wrote head packet", dat_rdata, 16'hA0A0);
        rd_word();
        chk("R6 rx area second word", dat_rdata, 16'hA1A1);
        set_pkt(2'd1);
        load_ptr(16'h8000);
        chk("R6 numbered packet untouched", dat_rdata, WD[0]);
        set_pkt(2'd0);
        load_ptr(16'hE000);
        chk("R6 rx area read", dat_rdata, 16'hA0A0);

        // offset wrap
        set_pkt(2'd3);
        load_ptr(16'h43FE);
        wr_word(16'h7E7E);
        chk("R2 wrap", ptr_rdata, 16'h5000);
        step();
        chk("R3 wrap drained", ptr_rdata, 16'h4000);
        load_ptr(16'h83FE);
        chk("R2 wrap word stored", dat_rdata, 16'h7E7E);

        // load and write in the same cycle
        load_ptr(16'h4010);
        ptr_we = 1'b1; ptr_wdata = 16'hC000; dat_we = 1'b1; dat_wdata = 16'hBEEF;
        step();
        ptr_we = 1'b0; dat_we = 1'b0;
        chk("R4 load dropped with write", ptr_rdata, 16'h5012);
        step();
        load_ptr(16'h8010);
        chk("R4 write used old pointer", dat_rdata, 16'hBEEF);

        // ignored pointer bits
        load_ptr(16'h5C01);
        chk("R1 ignored pointer bits", ptr_rdata, 16'h4000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule